// File: doc/BRIEF.md
# Fixed-Length Two-Chunk SHA-1 Core

This core computes the SHA-1 digest of a message whose length never changes: 672 bits by default. A run starts on a one-cycle request. The upper 512 message bits form the first compression block. The core keeps only the low tail bits for later. The second block is built inside the core from that tail, a single marker bit, a run of zeros and a 64-bit length field. Because the message length is a constant, the padding is wired in and the core always does exactly two compression passes.

Each pass takes one round per clock for 80 rounds. The message schedule lives in a 16-word sliding window that produces one new word per round. The five chaining words are updated after each pass. When the second pass ends, the ready flag rises and the 160-bit digest stays on the output. It stays there until the next request is accepted. A host typically presents a message, pulses the request, waits for ready and reads the digest. It may chain the next request in the same cycle that it sees ready.

Top module: `sha1_fixed672_core`

## Requirements
- R1: After reset is released, `done` is 0 and the core is idle.
- R2: A `go` pulse seen while the core is idle or done is accepted, and `done` is 0 in the cycle after the accepting clock edge.
- R3: `done` first reads 1 exactly 160 clock cycles after the accepting edge (two passes of 80 rounds).
- R4: `hash` equals the SHA-1 digest of `msg`. The first block is `msg[671:160]`, taken as big-endian 32-bit words with word 0 = `msg[671:640]`. The second block is `msg[159:0]`, then one 1 bit, then 287 zero bits, then a 64-bit length of 672 (0x2A0).
- R5: Each round uses Ch with constant 5A827999 for rounds 0–19, Parity with 6ED9EBA1 for rounds 20–39, Maj with 8F1BBCDC for rounds 40–59 and Parity with CA62C1D6 for rounds 60–79. The chaining state starts from the standard SHA-1 initial values and is updated by adding the working words modulo 2^32 after each block.
- R6: From round 16 on, schedule word t is the left-rotate by 1 of the XOR of words t-3, t-8, t-14 and t-16.
- R7: A `go` pulse during a run is ignored: it changes neither the digest nor the cycle on which `done` rises.
- R8: `msg` is sampled only at the accepting edge. Changes to `msg` after that edge do not affect the digest.
- R9: While `done` is 1 and no new request arrives, `done` stays 1 and `hash` stays stable.
- R10: A request raised in the same cycle that `done` is first seen is accepted and starts a correct new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Run request, sampled each rising edge |
| msg | input | 672 | Message, sampled when `go` is accepted |
| done | output | 1 | Digest valid |
| hash | output | 160 | Digest, word A in bits [159:128] |

## Verification
The bench changes `msg` right after each accepting edge. A core that reads the message late, or fails to latch the tail, then returns a digest of the altered message. Requests injected in the middle of a run would restart a core that does not ignore them, and that core would report `done` late with a different digest. Requests chained on the first `done` cycle catch a core that blocks acceptance while done, or that clears its state wrongly. A reference digest is computed for every message, and `done` is timed against 160 cycles. Any error in a round function, a constant, a schedule tap or the padding shows up as a digest mismatch, and a miscounted round shows up as a latency mismatch.

// File: rtl/sha1_fx_pkg.sv
package sha1_fx_pkg;
   typedef logic [31:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
   } hstate_t;

   localparam int ROUNDS  = 80;
   localparam int RND_W   = 7;
   localparam int BLK_BITS = 512;
   localparam int WIN_WORDS = 16;
   localparam int LEN_BITS = 64;

   function automatic hstate_t init_state();
      hstate_t s;
      s.a = 32'h67452301;
      s.b = 32'hEFCDAB89;
      s.c = 32'h98BADCFE;
      s.d = 32'h10325476;
      s.e = 32'hC3D2E1F0;
      return s;
   endfunction

   function automatic word_t rotl(input word_t x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function automatic word_t rnd_const(input logic [RND_W-1:0] t);
      if (t < 7'd20)      return 32'h5A827999;
      else if (t < 7'd40) return 32'h6ED9EBA1;
      else if (t < 7'd60) return 32'h8F1BBCDC;
      else                return 32'hCA62C1D6;
   endfunction

   function automatic word_t rnd_func(input logic [RND_W-1:0] t,
                                      input word_t b, input word_t c, input word_t d);
      if (t < 7'd20)      return (b & c) | (~b & d);
      else if (t < 7'd40) return b ^ c ^ d;
      else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
      else                return b ^ c ^ d;
   endfunction
endpackage

// File: rtl/sha1_fx_round.sv
module sha1_fx_round
   import sha1_fx_pkg::*;
(
   input  hstate_t              cur,
   input  word_t                w,
   input  logic [RND_W-1:0]     t,
   output hstate_t              nxt
);
   word_t mix;

   always_comb begin
      mix   = rotl(cur.a, 5) + rnd_func(t, cur.b, cur.c, cur.d) + cur.e + rnd_const(t) + w;
      nxt.a = mix;
      nxt.b = cur.a;
      nxt.c = rotl(cur.b, 30);
      nxt.d = cur.c;
      nxt.e = cur.d;
   end
endmodule

// File: rtl/sha1_fx_sched.sv
module sha1_fx_sched
   import sha1_fx_pkg::*;
#(
   parameter int WORDS = WIN_WORDS,
   parameter int TAP_A = 13,
   parameter int TAP_B = 8,
   parameter int TAP_C = 2
) (
   input  logic                   clk,
   input  logic                   load,
   input  logic [WORDS*32-1:0]    blk,
   input  logic                   step,
   output word_t                  w_now
);
   localparam int TOP = WORDS - 1;

   if (WORDS != 16 || TAP_A >= WORDS || TAP_B >= WORDS || TAP_C >= WORDS) begin : g_bad
      $error("sha1_fx_sched: window must be 16 words with taps inside it");
   end

   word_t win [WORDS];
   word_t fresh;

   assign fresh = rotl(win[TAP_A] ^ win[TAP_B] ^ win[TAP_C] ^ win[0], 1);
   assign w_now = win[0];

   for (genvar i = 0; i < WORDS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (load)
            win[i] <= blk[WORDS*32-1-32*i -: 32];
         else if (step) begin
            if (i == TOP) win[i] <= fresh;
            else          win[i] <= win[(i == TOP) ? 0 : i + 1];
         end
      end
   end
endmodule

// File: rtl/sha1_fx_ctrl.sv
module sha1_fx_ctrl
   import sha1_fx_pkg::*;
#(
   parameter int PASSES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   output logic               busy,
   output logic               done,
   output logic [RND_W-1:0]   rnd,
   output logic               accept,
   output logic               pass_end,
   output logic               run_end
);
   localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
   localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);
   localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(ROUNDS - 1);

   if (PASSES < 1) begin : g_bad
      $error("sha1_fx_ctrl: at least one pass required");
   end

   logic [PASS_W-1:0] pass_q;

   assign accept   = go & ~busy;
   assign pass_end = busy & (rnd == LAST_RND);
   assign run_end  = pass_end & (pass_q == LAST_PASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         rnd    <= '0;
         pass_q <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         rnd    <= '0;
         pass_q <= '0;
      end else if (busy) begin
         if (pass_end) begin
            rnd <= '0;
            if (run_end) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               pass_q <= pass_q + 1'b1;
            end
         end else begin
            rnd <= rnd + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sha1_fixed672_core.sv
module sha1_fixed672_core
   import sha1_fx_pkg::*;
#(
   parameter int MSG_BITS = 672
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [MSG_BITS-1:0] msg,
   output logic                done,
   output logic [159:0]        hash
);
   localparam int TAIL_BITS = MSG_BITS - BLK_BITS;
   localparam int ZERO_BITS = BLK_BITS - TAIL_BITS - 1 - LEN_BITS;

   if (TAIL_BITS < 1 || ZERO_BITS < 0) begin : g_bad
      $error("sha1_fixed672_core: message must fit exactly two blocks");
   end

   logic                  busy;
   logic [RND_W-1:0]      rnd;
   logic                  accept, pass_end, run_end;
   logic [TAIL_BITS-1:0]  tail_q;
   logic [BLK_BITS-1:0]   blk_first, blk_second, blk_sel;
   logic                  win_load;
   word_t                 w_now;
   hstate_t               h_q, work_q, work_nxt, sum;

   sha1_fx_ctrl #(.PASSES(2)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go),
      .busy(busy), .done(done), .rnd(rnd),
      .accept(accept), .pass_end(pass_end), .run_end(run_end)
   );

   assign blk_first  = msg[MSG_BITS-1 -: BLK_BITS];
   assign blk_second = {tail_q, 1'b1, {ZERO_BITS{1'b0}}, LEN_BITS'(MSG_BITS)};
   assign blk_sel    = accept ? blk_first : blk_second;
   assign win_load   = accept | (pass_end & ~run_end);

   sha1_fx_sched u_sched (
      .clk(clk), .load(win_load), .blk(blk_sel),
      .step(busy), .w_now(w_now)
   );

   sha1_fx_round u_round (
      .cur(work_q), .w(w_now), .t(rnd), .nxt(work_nxt)
   );

   always_comb begin
      sum.a = h_q.a + work_nxt.a;
      sum.b = h_q.b + work_nxt.b;
      sum.c = h_q.c + work_nxt.c;
      sum.d = h_q.d + work_nxt.d;
      sum.e = h_q.e + work_nxt.e;
   end

   always_ff @(posedge clk) begin
      if (accept) tail_q <= msg[TAIL_BITS-1:0];
   end

   always_ff @(posedge clk) begin
      if (accept)        work_q <= init_state();
      else if (pass_end) work_q <= sum;
      else if (busy)     work_q <= work_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        h_q <= '0;
      else if (accept)   h_q <= init_state();
      else if (pass_end) h_q <= sum;
   end

   assign hash = h_q;
endmodule

// File: rtl/sha1_fixed672_core_chk.sv
module sha1_fixed672_core_chk (
   input logic         clk,
   input logic         rst_n,
   input logic         go,
   input logic         busy,
   input logic         done,
   input logic [159:0] hash
);
   localparam int LAT = 160;
   logic [8:0] span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           span <= '0;
      else if (go && !busy) span <= '0;
      else if (busy)        span <= span + 1'b1;
   end

   // R2
   accept_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> (busy && !done));

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (span == 9'(LAT)));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !go) |=> (done && $stable(hash)));

   // R7
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go && span != 9'(LAT - 1)) |=> (busy && span != 0));
endmodule

bind sha1_fixed672_core sha1_fixed672_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .hash(hash)
);

// File: tb/sha1_fixed672_core_test.sv
`timescale 1ns/1ps
module sha1_fixed672_core_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         go = 1'b0;
   logic [671:0] msg = '0;
   logic         done;
   logic [159:0] hash;

   int n_run = 0, n_bad = 0;
   int cyc = 0;
   bit finished = 0;
   logic [159:0] exp_q [$];
   int           due_q [$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sha1_fixed672_core uut (
      .clk(clk), .rst_n(rst_n), .go(go), .msg(msg), .done(done), .hash(hash)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   // Reference digest from R4/R5/R6
   function automatic logic [159:0] ref_sha1(input logic [671:0] m);
      logic [1023:0] p;
      logic [31:0] h [5];
      logic [31:0] w [80];
      logic [31:0] a, b, c, d, e, f, k, tmp;
      logic [511:0] blk;
      p = {m, 1'b1, 287'b0, 64'd672};
      h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
      h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
      for (int bi = 0; bi < 2; bi++) begin
         blk = p[1023 - 512*bi -: 512];
         for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
         for (int t = 16; t < 80; t++) w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
         a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
         for (int t = 0; t < 80; t++) begin
            if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            tmp = rl(a, 5) + f + e + k + w[t];
            e = d; d = c; c = rl(b, 30); b = a; a = tmp;
         end
         h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
      end
      return {h[0], h[1], h[2], h[3], h[4]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: called at a falling edge; pushes expectation, then perturbs msg (R8)
   task automatic launch(input logic [671:0] m, input bit poke);
      go  = 1'b1;
      msg = m;
      exp_q.push_back(ref_sha1(m));
      due_q.push_back(cyc + 161);
      @(negedge clk);
      go  = 1'b0;
      msg = ~m;   // R8: late change must not matter
      check(done == 1'b0, "R2 done cleared after accept", {159'b0, done}, 160'd0);
      if (poke) begin
         repeat (40) @(negedge clk);
         go  = 1'b1;   // R7: ignored mid-run request
         msg = {m[335:0], m[671:336]};
         @(negedge clk);
         go  = 1'b0;
         repeat (70) @(negedge clk);
         go  = 1'b1;   // R7: second pass too
         @(negedge clk);
         go  = 1'b0;
      end
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   // Monitor: scoreboard pop on each rising done
   bit prev_done = 0;
   always @(negedge clk) begin
      if (rst_n && done && !prev_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected done", 160'd1, 160'd0);
         end else begin
            logic [159:0] e;
            int due;
            e   = exp_q.pop_front();
            due = due_q.pop_front();
            check(hash == e, "R4/R5/R6 digest", hash, e);
            check(cyc == due, "R3 latency", 160'(cyc), 160'(due));
         end
      end
      prev_done = done;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_run++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      logic [159:0] held;
      logic [671:0] m;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done low in reset", {159'b0, done}, 160'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1 done low after reset", {159'b0, done}, 160'd0);

      launch('0, 1'b0);
      wait_done();
      @(negedge clk);
      // R9: result held while idle
      held = hash;
      repeat (6) @(negedge clk);
      check(done == 1'b1, "R9 done held", {159'b0, done}, 160'd1);
      check(hash == held, "R9 hash stable", hash, held);

      launch({672{1'b1}}, 1'b1);   // R7 ignored requests
      wait_done();

      // R10: chained requests on the first done cycle
      m = '0;
      for (int i = 0; i < 21; i++) m[32*i +: 32] = 32'h9E3779B9 * (i + 1);
      launch(m, 1'b0);
      wait_done();
      launch({m[0 +: 336], m[336 +: 336]} ^ {84{8'hA5}}, 1'b0);
      wait_done();
      launch({8'h61, 664'b0} | 672'h1, 1'b1);
      wait_done();
      @(negedge clk);
      check(exp_q.size() == 0, "R3 all results seen", 160'(exp_q.size()), 160'd0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule